// File: doc/BRIEF.md
# Vector Predicate Pattern Generator

This block produces a lane-enable predicate for a scalable vector unit working on 32-bit elements. A run-time vector length and a 5-bit pattern code go in. A predicate with one bit per byte lane and three condition flags come out. The predicate enables a low prefix of elements whose size depends on the pattern and the element count. The patterns are a fixed count, the largest multiple of 3 or of 4, the largest power of two, or every element. When the pattern cannot be met at the current length, the predicate is all zero.

The logic is combinational: length clamp, count decoder, mask expansion and flag logic. An optional output register follows it, selected by a parameter and present by default. An issue stage drives the length and the pattern. When the instruction carries no pattern, it deasserts `pat_valid_i` and the generator then enables every element.

Top module: `pred_pattern_gen`

## Requirements
- R1: The length input is reduced to a legal length before use. Values from 128 to 2048 are rounded down to a multiple of 128. Values below 128 act as 128, and values above 2048 act as 2048. The element count is the legal length divided by 32, so it lies between 4 and 64.
- R2: Codes 1 to 8 request that many elements. Codes 9, 10, 11, 12 and 13 request 16, 32, 64, 128 and 256 elements. The requested count is enabled when it does not exceed the element count; otherwise no element is enabled.
- R3: Code 30 enables the largest multiple of 3 not above the element count. That is 3, 6, 15, 30 and 63 elements at lengths 128, 256, 512, 1024 and 2048.
- R4: Code 0 enables the largest power of two not above the element count. Code 29 enables the element count rounded down to a multiple of 4.
- R5: Code 31 enables every element. With `pat_valid_i` low, every element is enabled whatever the code.
- R6: Codes 14 to 28 are unallocated. They give an all-zero predicate with NONE set.
- R7: Element e maps to predicate bit 4*e, and bits 4*e+1 to 4*e+3 are always 0. The enabled elements form a contiguous run starting at element 0. All bits above that run, up to bit 255, are 0.
- R8: With at least one element enabled, FIRST=1, LAST=1 and NONE=0. With none enabled, FIRST=0, LAST=0 and NONE=1.
- R9: With REG_OUT=1, the outputs reflect inputs sampled at the previous rising clock edge. In reset the outputs show an empty predicate with NONE=1 and FIRST=LAST=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vl_i | input | 12 | Vector length in bits |
| pat_valid_i | input | 1 | Pattern present; low selects enable-all |
| pat_i | input | 5 | Pattern code |
| pred_o | output | 256 | Predicate, one bit per byte lane |
| first_o | output | 1 | First active element is enabled |
| last_o | output | 1 | Last active element is enabled |
| none_o | output | 1 | No element enabled |

## Verification
The hardest cases are where a fixed count sits exactly at the element count, and where the count is one above it. VL8 at 256 bits and VL16 at 512 bits flip from a full predicate to an empty one with a single length step. The stimulus sweeps all 32 codes across all sixteen legal lengths, so every such edge is hit in both directions. Illegal lengths below 128, between steps and above 2048 are then applied to check the clamp against the same reference.

// File: rtl/pred_gen_pkg.sv
package pred_gen_pkg;
  localparam int PAT_W = 5;

  localparam logic [PAT_W-1:0] PAT_POW2 = 5'd0;
  localparam logic [PAT_W-1:0] PAT_MUL4 = 5'd29;
  localparam logic [PAT_W-1:0] PAT_MUL3 = 5'd30;
  localparam logic [PAT_W-1:0] PAT_ALL  = 5'd31;

  // requested element count of a fixed-count code, 0 if not a fixed code
  function automatic logic [8:0] fixed_len(logic [PAT_W-1:0] code);
    logic [8:0] n;
    n = '0;
    if (code >= 5'd1 && code <= 5'd8) n = {4'd0, code};
    else begin
      case (code)
        5'd9:    n = 9'd16;
        5'd10:   n = 9'd32;
        5'd11:   n = 9'd64;
        5'd12:   n = 9'd128;
        5'd13:   n = 9'd256;
        default: n = 9'd0;
      endcase
    end
    return n;
  endfunction
endpackage

// File: rtl/vl_clamp.sv
module vl_clamp #(
  parameter int VL_W      = 12,
  parameter int VL_STEP   = 128,
  parameter int MAX_VL    = 2048,
  parameter int ELEM_BITS = 32,
  parameter int CNT_W     = 7
) (
  input  logic [VL_W-1:0]  vl_i,
  output logic [CNT_W-1:0] nelem_o
);
  localparam int STEP_SH   = $clog2(VL_STEP);
  localparam int MAX_STEPS = MAX_VL / VL_STEP;
  localparam int EPS       = VL_STEP / ELEM_BITS;
  localparam int EPS_SH    = $clog2(EPS);

  logic [VL_W-1:0] steps, legal_steps;

  always_comb begin
    steps = vl_i >> STEP_SH;
    if (steps == '0)                       legal_steps = VL_W'(1);
    else if (steps > VL_W'(MAX_STEPS))     legal_steps = VL_W'(MAX_STEPS);
    else                                   legal_steps = steps;
    nelem_o = CNT_W'(legal_steps << EPS_SH);
  end
endmodule

// File: rtl/pattern_count.sv
module pattern_count
  import pred_gen_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] nelem_i,
  input  logic             pat_valid_i,
  input  logic [PAT_W-1:0] pat_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] pow2_cnt, mul3_cnt, mul4_cnt, fixed_cnt;
  logic [8:0]       req;

  always_comb begin
    pow2_cnt = '0;
    for (int i = 0; i < CNT_W; i++)
      if (nelem_i[i]) pow2_cnt = CNT_W'(1) << i;
    mul3_cnt = nelem_i - (nelem_i % CNT_W'(3));
    mul4_cnt = nelem_i & ~CNT_W'(3);
    req      = fixed_len(pat_i);
    fixed_cnt = (int'(req) <= int'(nelem_i)) ? CNT_W'(req) : '0;
  end

  always_comb begin
    if (!pat_valid_i) cnt_o = nelem_i;
    else begin
      case (pat_i)
        PAT_POW2: cnt_o = pow2_cnt;
        PAT_MUL4: cnt_o = mul4_cnt;
        PAT_MUL3: cnt_o = mul3_cnt;
        PAT_ALL:  cnt_o = nelem_i;
        default:  cnt_o = fixed_cnt;  // 0 for unallocated codes
      endcase
    end
  end
endmodule

// File: rtl/prefix_mask.sv
module prefix_mask #(
  parameter int N_ELEM = 64,
  parameter int LPE    = 4,
  parameter int CNT_W  = 7
) (
  input  logic [CNT_W-1:0]      cnt_i,
  output logic [N_ELEM*LPE-1:0] mask_o,
  output logic                  last_o
);
  for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
    assign mask_o[e*LPE] = cnt_i > CNT_W'(e);
    for (genvar j = 1; j < LPE; j++) begin : g_pad
      assign mask_o[e*LPE+j] = 1'b0;
    end
  end

  // last active element of the result, governed by the result itself
  always_comb begin
    last_o = 1'b0;
    for (int e = 0; e < N_ELEM; e++)
      if (cnt_i == CNT_W'(e + 1)) last_o = mask_o[e*LPE];
  end
endmodule

// File: rtl/pred_pattern_gen.sv
module pred_pattern_gen
  import pred_gen_pkg::*;
#(
  parameter int VL_W      = 12,
  parameter int VL_STEP   = 128,
  parameter int MAX_VL    = 2048,
  parameter int ELEM_BITS = 32,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [VL_W-1:0]       vl_i,
  input  logic                  pat_valid_i,
  input  logic [PAT_W-1:0]      pat_i,
  output logic [MAX_VL/8-1:0]   pred_o,
  output logic                  first_o,
  output logic                  last_o,
  output logic                  none_o
);
  localparam int N_ELEM = MAX_VL / ELEM_BITS;
  localparam int LPE    = ELEM_BITS / 8;
  localparam int PW     = MAX_VL / 8;
  localparam int CNT_W  = $clog2(N_ELEM + 1);

  logic [CNT_W-1:0] nelem, cnt;
  logic [PW-1:0]    mask_c;
  logic             first_c, last_c, none_c;

  vl_clamp #(.VL_W(VL_W), .VL_STEP(VL_STEP), .MAX_VL(MAX_VL),
             .ELEM_BITS(ELEM_BITS), .CNT_W(CNT_W)) u_clamp (
    .vl_i(vl_i), .nelem_o(nelem));

  pattern_count #(.CNT_W(CNT_W)) u_count (
    .nelem_i(nelem), .pat_valid_i(pat_valid_i), .pat_i(pat_i), .cnt_o(cnt));

  prefix_mask #(.N_ELEM(N_ELEM), .LPE(LPE), .CNT_W(CNT_W)) u_mask (
    .cnt_i(cnt), .mask_o(mask_c), .last_o(last_c));

  assign first_c = mask_c[0];
  assign none_c  = ~|mask_c;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pred_o  <= '0;
        first_o <= 1'b0;
        last_o  <= 1'b0;
        none_o  <= 1'b1;
      end else begin
        pred_o  <= mask_c;
        first_o <= first_c;
        last_o  <= last_c;
        none_o  <= none_c;
      end
    end
  end else begin : g_comb
    assign pred_o  = mask_c;
    assign first_o = first_c;
    assign last_o  = last_c;
    assign none_o  = none_c;
  end

  // element view of the output for the prefix check
  logic [N_ELEM-1:0] elem_on;
  for (genvar e = 0; e < N_ELEM; e++) begin : g_view
    assign elem_on[e] = pred_o[e*LPE];
  end

  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= nelem);
  a_r5_default_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pat_valid_i |-> cnt == nelem);
  a_r7_prefix_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((elem_on + N_ELEM'(1)) & elem_on) == '0);
  a_r8_flags_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_o == last_o) && (none_o == !first_o));
  a_r6_none_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    none_o |-> pred_o == '0);
endmodule

// File: tb/pred_pattern_gen_test.sv
module pred_pattern_gen_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  vl = 12'd128;
  logic         pat_valid = 1'b1;
  logic [4:0]   pat = 5'd31;
  logic [255:0] pred;
  logic         first, last, none;
  int           checks = 0;
  int           errors = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  pred_pattern_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .vl_i(vl), .pat_valid_i(pat_valid),
    .pat_i(pat), .pred_o(pred), .first_o(first), .last_o(last), .none_o(none));

  function automatic int legal_elems(int v);
    int s = v / 128;
    if (s < 1) s = 1;
    if (s > 16) s = 16;
    return s * 4;
  endfunction

  function automatic int ref_count(int v, bit valid, int code);
    int n = legal_elems(v);
    int p = 1;
    int req [int];
    req[9] = 16; req[10] = 32; req[11] = 64; req[12] = 128; req[13] = 256;
    if (!valid || code == 31) return n;
    if (code == 0) begin
      while (p * 2 <= n) p = p * 2;
      return p;
    end
    if (code == 29) return (n / 4) * 4;
    if (code == 30) return (n / 3) * 3;
    if (code >= 1 && code <= 8) return (code <= n) ? code : 0;
    if (req.exists(code)) return (req[code] <= n) ? req[code] : 0;
    return 0;
  endfunction

  function automatic string tag(bit valid, int code);
    if (!valid || code == 31) return "R5";
    if (code == 0 || code == 29) return "R4";
    if (code == 30) return "R3";
    if (code >= 1 && code <= 13) return "R2";
    return "R6";
  endfunction

  task automatic compare(string rq, int c);
    logic [255:0] exp_p = '0;
    for (int e = 0; e < c; e++) exp_p[e*4] = 1'b1;
    checks++;
    if (pred !== exp_p) begin
      errors++;
      $display("FAIL %s/R7 pred vl=%0d pat=%0d act=%h exp=%h", rq, vl, pat, pred, exp_p);
    end
    checks++;
    if ({first, last, none} !== ((c > 0) ? 3'b110 : 3'b001)) begin
      errors++;
      $display("FAIL R8 flags vl=%0d pat=%0d act=%b exp=%b", vl, pat,
               {first, last, none}, (c > 0) ? 3'b110 : 3'b001);
    end
  endtask

  task automatic apply(int v, bit valid, int code, string extra);
    vl = 12'(v); pat_valid = valid; pat = 5'(code);
    @(posedge clk);
    @(negedge clk);  // R9: one register stage
    compare(extra.len() ? extra : tag(valid, code), ref_count(v, valid, code));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R9 reset state
    if (pred !== '0 || {first, last, none} !== 3'b001) begin
      errors++;
      $display("FAIL R9 reset act=%b exp=001", {first, last, none});
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 1; s <= 16; s++)
      for (int c = 0; c < 32; c++) apply(s * 128, 1'b1, c, "");
    // R5: absent pattern selects all, whatever the code
    apply(512, 1'b0, 3, "R5");
    apply(2048, 1'b0, 20, "R5");
    // R2 boundaries around the element count
    apply(256, 1'b1, 8, "R2");
    apply(128, 1'b1, 8, "R2");
    apply(512, 1'b1, 9, "R2");
    apply(384, 1'b1, 9, "R2");
    // R1 illegal lengths
    apply(0, 1'b1, 31, "R1");
    apply(100, 1'b1, 4, "R1");
    apply(200, 1'b1, 31, "R1");
    apply(1000, 1'b1, 30, "R1");
    apply(2100, 1'b1, 11, "R1");
    apply(4095, 1'b1, 31, "R1");
    // R9: output holds the sample of the previous edge
    vl = 12'd2048; pat = 5'd31; pat_valid = 1'b1;
    @(posedge clk);
    #1 pat = 5'd20;
    @(negedge clk);
    compare("R9", 64);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule